// File: doc/BRIEF.md
# Bit-Serial Shift and Rotate Unit

This block carries out the seven classic shift and rotate kinds on a byte-wide or word-wide operand, moving the data one bit position per clock. A request presents an operation code, a width select, the operand, a repeat count and the incoming carry flag together with a start strobe. The unit then steps the value once per cycle, with the carry flag taking part in the data path. Both rotate-through-carry kinds treat the carry as one extra ring bit, and every kind leaves the last bit pushed out of the active field in the carry. When the count is used up, a one-cycle completion pulse marks the cycle in which the result, carry and overflow outputs are valid.

In byte mode only the low field of the operand moves, and its top bit acts as the most significant bit. The bits above that field pass through unchanged. A zero count is a legal request that returns the operand and the incoming carry untouched and keeps the previous overflow value.

Top module: `shift_rotate_seq`

## Requirements
- R1: After reset, result, cf_out, of_out, busy and done are all zero.
- R2: Code 0 (rotate left) moves the active MSB into both the LSB and cf_out at each step.
- R3: Code 1 (rotate right) moves the LSB into both the active MSB and cf_out at each step.
- R4: Code 2 (rotate left through carry) moves the MSB into the carry and the previous carry into the LSB. Code 3 (rotate right through carry) moves the LSB into the carry and the previous carry into the MSB.
- R5: Codes 4 and 7 (logical/arithmetic left shift) give identical results: the MSB goes to the carry and a zero enters the LSB. Code 5 (logical right shift) moves the LSB into the carry and feeds a zero into the MSB.
- R6: Code 6 (arithmetic right shift) moves the LSB into the carry and keeps the sign bit in place, so its overflow output is always 0 after a nonzero count.
- R7: With byte_mode=1 only bits 7:0 move and bit 7 is the MSB, while result bits 15:8 equal the operand's bits 15:8. With byte_mode=0 all 16 bits move and bit 15 is the MSB.
- R8: An accepted start with count N>0 raises busy and performs one bit step per clock. done pulses for exactly one cycle, N+1 clocks after the start edge, with busy low in that cycle.
- R9: A count of zero gives result = operand and cf_out = cf_in, leaves of_out at its previous value, and pulses done one clock after the start edge.
- R10: After a nonzero count, of_out is computed from the final result. For left kinds (codes 0, 2, 4, 7) it is the result MSB XOR cf_out. For right kinds (codes 1, 3, 5, 6) it is the XOR of the two top bits of the active field.
- R11: A start while busy is ignored. While idle with no start, result, cf_out and of_out hold their values.
- R12: In byte mode, rotating 0x1C left by one gives 0x38 with carry 0, and rotating 0x1C right by one gives 0x0E with carry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted only while idle |
| op_sel | input | 3 | Shift/rotate kind code (see R2 to R6) |
| byte_mode | input | 1 | 1 selects the narrow field, 0 the full word |
| operand | input | WIDE_W (16) | Value to shift |
| count | input | CNT_W (5) | Number of bit steps |
| cf_in | input | 1 | Incoming carry flag |
| result | output | WIDE_W (16) | Shifted value |
| cf_out | output | 1 | Carry flag result |
| of_out | output | 1 | Overflow flag result |
| busy | output | 1 | High while steps remain |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default build: a 16-bit word, an 8-bit narrow field and a 5-bit count. Counts therefore run up to 31, well past both field widths, so the carry ring and fill behaviour are exercised across several full revolutions. The narrow field is small enough to sweep every one of its 256 operand values for each code and both carry inputs at a single step. Each code also runs at counts 0 to 31 in both widths against an arithmetic model.

// File: rtl/sr_pkg.sv
package sr_pkg;
   typedef enum logic [2:0] {
      SR_ROL = 3'd0,
      SR_ROR = 3'd1,
      SR_RCL = 3'd2,
      SR_RCR = 3'd3,
      SR_SHL = 3'd4,
      SR_SHR = 3'd5,
      SR_SAR = 3'd6,
      SR_SAL = 3'd7
   } sr_op_e;

   function automatic logic sr_is_left(input sr_op_e op);
      return (op == SR_ROL) || (op == SR_RCL) || (op == SR_SHL) || (op == SR_SAL);
   endfunction
endpackage

// File: rtl/sr_bit_step.sv
module sr_bit_step
   import sr_pkg::*;
#(
   parameter int WIDE_W   = 16,
   parameter int NARROW_W = 8
) (
   input  sr_op_e              op,
   input  logic                narrow,
   input  logic [WIDE_W-1:0]   val,
   input  logic                cf,
   output logic [WIDE_W-1:0]   nxt,
   output logic                nxt_cf
);
   logic msb, lsb, ins, left;

   assign msb  = narrow ? val[NARROW_W-1] : val[WIDE_W-1];
   assign lsb  = val[0];
   assign left = sr_is_left(op);

   always_comb begin
      case (op)
         SR_ROL:  ins = msb;
         SR_ROR:  ins = lsb;
         SR_RCL,
         SR_RCR:  ins = cf;
         SR_SAR:  ins = msb;
         default: ins = 1'b0;
      endcase
   end

   assign nxt_cf = left ? msb : lsb;

   genvar i;
   generate
      for (i = 0; i < WIDE_W; i++) begin : g_bit
         localparam bit IN_NARROW = (i < NARROW_W);
         localparam bit NARROW_TOP = (i == NARROW_W - 1);
         logic active, lv, rv;
         assign active = !narrow || IN_NARROW;
         if (i == 0) begin : g_lo
            assign lv = ins;
         end else begin : g_lmid
            assign lv = active ? val[i-1] : val[i];
         end
         if (i == WIDE_W - 1) begin : g_hi
            assign rv = narrow ? val[i] : ins;
         end else begin : g_rmid
            assign rv = !active ? val[i] : ((narrow && NARROW_TOP) ? ins : val[i+1]);
         end
         assign nxt[i] = left ? lv : rv;
      end
   endgenerate
endmodule

// File: rtl/sr_of_eval.sv
module sr_of_eval
   import sr_pkg::*;
#(
   parameter int WIDE_W   = 16,
   parameter int NARROW_W = 8
) (
   input  sr_op_e              op,
   input  logic                narrow,
   input  logic [WIDE_W-1:0]   res,
   input  logic                cf,
   output logic                of
);
   logic top, below;
   assign top   = narrow ? res[NARROW_W-1] : res[WIDE_W-1];
   assign below = narrow ? res[NARROW_W-2] : res[WIDE_W-2];
   assign of    = sr_is_left(op) ? (top ^ cf) : (top ^ below);
endmodule

// File: rtl/sr_seq_ctrl.sv
module sr_seq_ctrl #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] count,
   output logic             load,
   output logic             step_en,
   output logic             finish,
   output logic             had_steps,
   output logic             busy,
   output logic             done
);
   logic [CNT_W-1:0] rem_q;
   logic             busy_q, done_q, steps_q;

   assign load      = start && !busy_q;
   assign step_en   = busy_q && (rem_q != '0);
   assign finish    = busy_q && (rem_q == '0);
   assign had_steps = steps_q;
   assign busy      = busy_q;
   assign done      = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q   <= '0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         steps_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (load) begin
            busy_q  <= 1'b1;
            rem_q   <= count;
            steps_q <= (count != '0);
         end else if (busy_q) begin
            if (rem_q == '0) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               rem_q <= rem_q - 1'b1;
            end
         end
      end
   end

   AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_q && done_q)); // R8
   AST_REM_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && rem_q != '0) |=> (busy_q && rem_q == $past(rem_q) - 1'b1)); // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R8
endmodule

// File: rtl/shift_rotate_seq.sv
module shift_rotate_seq
   import sr_pkg::*;
#(
   parameter int WIDE_W   = 16,
   parameter int NARROW_W = 8,
   parameter int CNT_W    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        op_sel,
   input  logic              byte_mode,
   input  logic [WIDE_W-1:0] operand,
   input  logic [CNT_W-1:0]  count,
   input  logic              cf_in,
   output logic [WIDE_W-1:0] result,
   output logic              cf_out,
   output logic              of_out,
   output logic              busy,
   output logic              done
);
   localparam int UPPER_LO = NARROW_W;

   generate
      if (NARROW_W < 2 || NARROW_W >= WIDE_W) begin : g_bad_width
         $error("NARROW_W must be at least 2 and below WIDE_W");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
   endgenerate

   logic              load, step_en, finish, had_steps;
   logic [WIDE_W-1:0] val_q, step_val;
   logic              cf_q, of_q, step_cf, of_calc, nar_q;
   sr_op_e            op_q;

   sr_seq_ctrl #(.CNT_W(CNT_W)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .start(start), .count(count),
      .load(load), .step_en(step_en), .finish(finish),
      .had_steps(had_steps), .busy(busy), .done(done)
   );

   sr_bit_step #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) step_i (
      .op(op_q), .narrow(nar_q), .val(val_q), .cf(cf_q),
      .nxt(step_val), .nxt_cf(step_cf)
   );

   sr_of_eval #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) ofe_i (
      .op(op_q), .narrow(nar_q), .res(val_q), .cf(cf_q), .of(of_calc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val_q <= '0;
         cf_q  <= 1'b0;
         of_q  <= 1'b0;
         op_q  <= SR_ROL;
         nar_q <= 1'b0;
      end else if (load) begin
         val_q <= operand;
         cf_q  <= cf_in;
         op_q  <= sr_op_e'(op_sel);
         nar_q <= byte_mode;
      end else if (step_en) begin
         val_q <= step_val;
         cf_q  <= step_cf;
      end else if (finish && had_steps) begin
         of_q <= of_calc;
      end
   end

   assign result = val_q;
   assign cf_out = cf_q;
   assign of_out = of_q;

   AST_ZERO_COUNT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && count == '0) |=> ##1 (done && result == $past(operand, 2) && cf_out == $past(cf_in, 2))); // R9
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(result) && $stable(cf_out) && $stable(of_out))); // R11
   AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && nar_q) |=> (result[WIDE_W-1:UPPER_LO] == $past(result[WIDE_W-1:UPPER_LO]))); // R7
   AST_SAR_NO_OF: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_q == SR_SAR && had_steps) |-> !of_out); // R6
endmodule

// File: tb/shift_rotate_seq_tb_top.sv
`timescale 1ns/1ps
module shift_rotate_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op_sel = '0;
   logic        byte_mode = 1'b0;
   logic [15:0] operand = '0;
   logic [4:0]  count = '0;
   logic        cf_in = 1'b0;
   logic [15:0] result;
   logic        cf_out, of_out, busy, done;

   int total = 0;
   int bad = 0;
   bit exp_of = 1'b0;

   always #5 clk = ~clk;

   shift_rotate_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
      .byte_mode(byte_mode), .operand(operand), .count(count), .cf_in(cf_in),
      .result(result), .cf_out(cf_out), .of_out(of_out), .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   function automatic string op_req(input int op);
      case (op)
         0: return "R2";
         1: return "R3";
         2, 3: return "R4";
         6: return "R6";
         default: return "R5";
      endcase
   endfunction

   // arithmetic model of the requirement set
   task automatic model(input int op, input bit nar, input logic [15:0] opnd,
                        input int cnt, input bit cin,
                        output logic [15:0] res, output bit cf, output bit of);
      int w = nar ? 8 : 16;
      int mask = (1 << w) - 1;
      int v = int'(opnd) & mask;
      bit c = cin;
      for (int s = 0; s < cnt; s++) begin
         int hi = (v >> (w - 1)) & 1;
         int lo = v & 1;
         case (op)
            0: begin v = ((v << 1) & mask) | hi; c = hi[0]; end
            1: begin v = (v >> 1) | (lo << (w - 1)); c = lo[0]; end
            2: begin v = ((v << 1) & mask) | int'(c); c = hi[0]; end
            3: begin v = (v >> 1) | (int'(c) << (w - 1)); c = lo[0]; end
            5: begin v = v >> 1; c = lo[0]; end
            6: begin v = (v >> 1) | (hi << (w - 1)); c = lo[0]; end
            default: begin v = (v << 1) & mask; c = hi[0]; end
         endcase
      end
      res = 16'((int'(opnd) & ~mask & 32'hFFFF) | v);
      cf = c;
      if (cnt == 0) of = exp_of;
      else if (op == 0 || op == 2 || op == 4 || op == 7) of = res[w-1] ^ c;
      else of = res[w-1] ^ res[w-2];
   endtask

   task automatic issue(input int op, input bit nar, input logic [15:0] opnd,
                        input int cnt, input bit cin);
      op_sel = 3'(op); byte_mode = nar; operand = opnd; count = 5'(cnt); cf_in = cin;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic finish_run(input int op, input bit nar, input logic [15:0] opnd,
                             input int cnt, input bit cin, input bit full);
      logic [15:0] er;
      bit ec, eo;
      int k = 0;
      string rq;
      model(op, nar, opnd, cnt, cin, er, ec, eo);
      while (!done && k < 40) begin
         @(negedge clk);
         k++;
      end
      rq = nar ? {op_req(op), "/R7"} : op_req(op);
      if (full) chk(k == cnt + 1, (cnt == 0) ? "R9" : "R8", "latency", k, cnt + 1);
      chk(result == er, (cnt == 0) ? "R9" : rq, "result", result, er);
      chk(cf_out == ec, (cnt == 0) ? "R9" : rq, "cf", cf_out, ec);
      chk(of_out == eo, (cnt == 0) ? "R9" : ((op == 6) ? "R6" : "R10"), "of", of_out, eo);
      exp_of = eo;
      if (full) begin
         chk(busy == 1'b0, "R8", "busy at done", busy, 0);
         @(negedge clk);
         chk(done == 1'b0, "R8", "done one cycle", done, 0);
      end
   endtask

   task automatic run(input int op, input bit nar, input logic [15:0] opnd,
                      input int cnt, input bit cin, input bit full);
      issue(op, nar, opnd, cnt, cin);
      finish_run(op, nar, opnd, cnt, cin, full);
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R8 watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [15:0] pats [6] = '{16'h0000, 16'hFFFF, 16'h8001, 16'hA55A, 16'h1C3E, 16'h7F80};
      logic [15:0] hold_r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(result == 16'h0 && cf_out == 1'b0 && of_out == 1'b0, "R1", "reset data", result, 0);
      chk(busy == 1'b0 && done == 1'b0, "R1", "reset ctrl", {busy, done}, 0);

      // R12 reference cases
      run(0, 1'b1, 16'h001C, 1, 1'b0, 1'b1);
      chk(result == 16'h0038 && cf_out == 1'b0, "R12", "rol ref", result, 16'h0038);
      run(1, 1'b1, 16'h001C, 1, 1'b0, 1'b1);
      chk(result == 16'h000E && cf_out == 1'b0, "R12", "ror ref", result, 16'h000E);

      // exhaustive narrow single-step sweep: R2 R3 R4 R5 R6 R7 R10
      for (int op = 0; op < 8; op++)
         for (int c = 0; c < 2; c++)
            for (int v = 0; v < 256; v++)
               run(op, 1'b1, 16'(v) | 16'h5A00, 1, c[0], 1'b0);

      // multi-count sweep in both widths: R8 R9 R10
      for (int op = 0; op < 8; op++)
         for (int nar = 0; nar < 2; nar++)
            for (int c = 0; c < 2; c++)
               for (int p = 0; p < 6; p++)
                  for (int n = 0; n < 32; n += (p < 2) ? 5 : 1)
                     run(op, nar[0], pats[p], n, c[0], 1'b1);

      // R5: SHL and SAL codes agree
      run(4, 1'b0, 16'hC3A5, 3, 1'b1, 1'b1);
      hold_r = result;
      run(7, 1'b0, 16'hC3A5, 3, 1'b1, 1'b1);
      chk(result == hold_r, "R5", "sal equals shl", result, hold_r);

      // R11: start while busy is ignored
      issue(0, 1'b0, 16'h8001, 10, 1'b0);
      @(negedge clk);
      @(negedge clk);
      op_sel = 3'd5; operand = 16'hFFFF; count = 5'd0; cf_in = 1'b1; byte_mode = 1'b1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      finish_run(0, 1'b0, 16'h8001, 10, 1'b0, 1'b0);
      chk(busy == 1'b0, "R11", "run ended", busy, 0);
      hold_r = result;
      operand = 16'h1234; cf_in = ~cf_out;
      repeat (4) @(negedge clk);
      chk(result == hold_r, "R11", "idle hold", result, hold_r);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule